// File: doc/BRIEF.md
# Serial-Load Programming Register with Hold Latch

This block is the programming port of a frequency synthesizer. A host sends a 16-bit control word one bit at a time on a serial data line, with a serial clock. A separate load enable copies the word into a holding register. The holding register drives a 14-bit divide-by-N value for the programmable counter and two general-purpose switch outputs. While the load enable is low, the host can shift a complete new word in and the programmed value and the switches do not change. A short high pulse on the enable then applies the new word. If the enable is held high, the outputs follow the shift register as each bit arrives.

The serial clock, serial data and load enable come from pins that have no timing relation to the core. All three pass through a synchronizer of `SYNC_STAGES` flops, and the block does all of its work on the core clock `clk`. A rising edge of the serial clock, detected after synchronization, shifts one bit in. Each serial clock level must therefore stay stable for more than `SYNC_STAGES + 1` core cycles. An enable pin that is left floating (X or Z in simulation) reads as high, which matches a pulled-up pin.

Top module: `spl_prog_reg`

## Requirements
- R1: Each rising edge of `ser_clk_i` shifts exactly one bit, the `ser_data_i` value present at that edge, into the 16-bit shift register. Falling edges and steady levels of `ser_clk_i` leave the shift register unchanged.
- R2: After exactly 16 shifts, the first bit shifted in maps to `switch_o[1]`, the second bit maps to `switch_o[0]`, and the remaining 14 bits form `div_n_o` MSB first, so the last bit shifted in is `div_n_o[0]`.
- R3: While `load_en_i` is high, `switch_o` and `div_n_o` follow the shift register contents and track every newly shifted bit.
- R4: While `load_en_i` is low, `switch_o` and `div_n_o` keep their values even while new bits are shifted in.
- R5: Reset (`rst_ni` low) clears the shift register and sets `div_n_o` to 0 and `switch_o` to 2'b00. A load pulse given after reset with no shifts still produces all zeros.
- R6: The shift register is never cleared by a load. A load after fewer than 16 new shifts applies the older bits shifted left by the number of new bits, with the new bits at the low end.
- R7: When more than 16 bits are shifted before a load, only the last 16 bits remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_clk_i | input | 1 | Serial shift clock; a bit is taken on each rising edge |
| ser_data_i | input | 1 | Serial data |
| load_en_i | input | 1 | Load enable: transparent while high, hold while low |
| div_n_o | output | 14 | Held divide-by-N value |
| switch_o | output | 2 | Held switch outputs; bit 1 comes from the first bit shifted in |

## Verification
The checker tests four things on every cycle: the hold register does not change while the synchronized enable is low; it copies the shift register while the enable is high; the shift register moves only on a detected serial clock rise, and by exactly one bit; and reset drives the outputs to zero. Only the bench scenarios can show the end-to-end results at the ports. These are the field split and bit order of a full word, the hold of an old word while a new one is shifted in, partial and over-long words, and outputs that track bit by bit while the enable is held high.

// File: rtl/spl_pkg.sv
package spl_pkg;
  // Default geometry of the programming word.
  localparam int unsigned DEF_N_W    = 14;
  localparam int unsigned DEF_SW_W   = 2;
  localparam int unsigned DEF_SYNC   = 2;
endpackage

// File: rtl/spl_rst_sync.sv
// Reset conditioner: asserts asynchronously, deasserts on clk after STAGES edges.
module spl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/spl_sync.sv
// Multi-bit flop synchronizer; every bit sees the same number of stages so
// signals that arrive together also leave together.
module spl_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = d_i;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) begin
        stage_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spl_shift_reg.sv
// Edge detector on the synchronized serial clock and the serial shift register.
module spl_shift_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         sclk_i,
  input  logic         sdat_i,
  output logic         stb_o,
  output logic [W-1:0] sr_o
);
  logic         sclk_prev_q;
  logic         sclk_prev_d;
  logic [W-1:0] sr_q;
  logic [W-1:0] sr_d;
  logic         shift_en;

  // Next-state logic
  always_comb begin
    shift_en    = sclk_i & ~sclk_prev_q;
    sclk_prev_d = sclk_i;
    sr_d        = sr_q;
    if (shift_en) begin
      sr_d = {sr_q[W-2:0], sdat_i};
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      sr_q        <= '0;
    end else begin
      sclk_prev_q <= sclk_prev_d;
      if (shift_en) begin
        sr_q <= sr_d;
      end
    end
  end

  assign stb_o = shift_en;
  assign sr_o  = sr_q;
endmodule

// File: rtl/spl_hold_reg.sv
// Holding register: copies the shift register while enabled, holds otherwise.
module spl_hold_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;

  always_comb begin
    hold_d = en_i ? d_i : hold_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else begin
      if (en_i) begin
        hold_q <= hold_d;
      end
    end
  end

  assign q_o = hold_q;
endmodule

// File: rtl/spl_prog_reg.sv
// Serial-load programming register: top level.
module spl_prog_reg
  import spl_pkg::*;
#(
  parameter int unsigned N_W         = DEF_N_W,
  parameter int unsigned SW_W        = DEF_SW_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            ser_clk_i,
  input  logic            ser_data_i,
  input  logic            load_en_i,
  output logic [N_W-1:0]  div_n_o,
  output logic [SW_W-1:0] switch_o
);
  localparam int unsigned W     = N_W + SW_W;
  localparam int unsigned IN_W  = 3;
  localparam int unsigned I_CLK = 0;
  localparam int unsigned I_DAT = 1;
  localparam int unsigned I_EN  = 2;

  logic            rst_n_s;
  logic            en_raw;
  logic [IN_W-1:0] pins_raw;
  logic [IN_W-1:0] pins_s;
  logic            sclk_s;
  logic            dat_s;
  logic            en_s;
  logic            shift_stb;
  logic [W-1:0]    sr_q;
  logic [W-1:0]    hold_q;

  spl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  // A floating enable (X or Z) reads as high, like a pulled-up pin; any
  // driven level passes through unchanged.
  always_comb begin
    en_raw = (load_en_i !== 1'b0);
  end

  assign pins_raw = {en_raw, ser_data_i, ser_clk_i};

  spl_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_ni (rst_n_s),
    .d_i    (pins_raw),
    .q_o    (pins_s)
  );

  assign sclk_s = pins_s[I_CLK];
  assign dat_s  = pins_s[I_DAT];
  assign en_s   = pins_s[I_EN];

  spl_shift_reg #(.W(W)) u_shift (
    .clk    (clk),
    .rst_ni (rst_n_s),
    .sclk_i (sclk_s),
    .sdat_i (dat_s),
    .stb_o  (shift_stb),
    .sr_o   (sr_q)
  );

  spl_hold_reg #(.W(W)) u_hold (
    .clk    (clk),
    .rst_ni (rst_n_s),
    .en_i   (en_s),
    .d_i    (sr_q),
    .q_o    (hold_q)
  );

  // The first bits shifted in sit at the top of the word: switches above N.
  assign switch_o = hold_q[W-1 -: SW_W];
  assign div_n_o  = hold_q[N_W-1:0];
endmodule

// File: rtl/spl_prog_reg_chk.sv
module spl_prog_reg_chk #(
  parameter int unsigned N_W  = 14,
  parameter int unsigned SW_W = 2
) (
  input logic                clk,
  input logic                rst_ni,
  input logic                shift_stb,
  input logic                en_s,
  input logic                dbit,
  input logic [N_W+SW_W-1:0] sr,
  input logic [N_W-1:0]      div_n,
  input logic [SW_W-1:0]     sw
);
  localparam int unsigned W = N_W + SW_W;

  // R4: outputs frozen while the enable is closed
  a_r4_hold_closed: assert property (@(posedge clk) disable iff (!rst_ni)
    !en_s |=> ($stable(div_n) && $stable(sw)));

  // R3: outputs copy the shift register while the enable is open
  a_r3_follow_open: assert property (@(posedge clk) disable iff (!rst_ni)
    en_s |=> ({sw, div_n} == $past(sr)));

  // R1: no shift without a detected serial clock rise
  a_r1_no_spurious_shift: assert property (@(posedge clk) disable iff (!rst_ni)
    !shift_stb |=> $stable(sr));

  // R1: a rise moves the word by exactly one bit
  a_r1_one_bit_shift: assert property (@(posedge clk) disable iff (!rst_ni)
    shift_stb |=> (sr == {$past(sr[W-2:0]), $past(dbit)}));

  // R1: one rise gives one strobe, never two in a row
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_ni)
    shift_stb |=> !shift_stb);

  // R5: reset clears the outputs
  a_r5_reset_clear: assert property (@(posedge clk)
    !rst_ni |=> (div_n == '0 && sw == '0));
endmodule

bind spl_prog_reg spl_prog_reg_chk #(.N_W(N_W), .SW_W(SW_W)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .shift_stb (shift_stb),
  .en_s      (en_s),
  .dbit      (dat_s),
  .sr        (sr_q),
  .div_n     (div_n_o),
  .sw        (switch_o)
);

// File: tb/spl_prog_reg_bench.sv
module spl_prog_reg_bench;
  localparam int N_W  = 14;
  localparam int SW_W = 2;
  localparam int W    = 16;
  localparam int PH   = 6;   // core cycles per serial clock level
  localparam int SET  = 8;   // settle after an enable change

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_ni;
  logic            ser_clk;
  logic            ser_data;
  logic            load_en;
  logic [N_W-1:0]  div_n_o;
  logic [SW_W-1:0] switch_o;

  spl_prog_reg u_spl_prog_reg (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .ser_clk_i  (ser_clk),
    .ser_data_i (ser_data),
    .load_en_i  (load_en),
    .div_n_o    (div_n_o),
    .switch_o   (switch_o)
  );

  typedef struct {
    logic [W-1:0] v;
    string        tag;
  } exp_t;

  exp_t         exp_q[$];
  exp_t         cur;
  event         ev_cmp;
  int           n_cmp = 0;
  int           n_bad = 0;
  bit           done  = 0;
  logic [W-1:0] mdl_sr;
  logic [W-1:0] held;

  // Monitor: pops expected items and compares them with the outputs.
  initial begin
    forever begin
      @(ev_cmp);
      while (exp_q.size() > 0) begin
        cur = exp_q.pop_front();
        n_cmp++;
        if ({switch_o, div_n_o} !== cur.v) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", cur.tag, {switch_o, div_n_o}, cur.v);
        end
      end
    end
  end

  task automatic expect_out(input logic [W-1:0] v, input string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    exp_q.push_back(e);
    ->ev_cmp;
    @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_data = b;
    repeat (PH) @(negedge clk);
    ser_clk = 1'b1;
    mdl_sr = {mdl_sr[W-2:0], b};
    repeat (PH) @(negedge clk);
    ser_clk = 1'b0;
    repeat (PH) @(negedge clk);
  endtask

  task automatic shift_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse_load();
    load_en = 1'b1;
    repeat (SET) @(negedge clk);
    load_en = 1'b0;
    repeat (SET) @(negedge clk);
    held = mdl_sr;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w;
    rst_ni   = 1'b0;
    ser_clk  = 1'b0;
    ser_data = 1'b0;
    load_en  = 1'b0;
    mdl_sr   = '0;
    held     = '0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (SET) @(negedge clk);

    // R5: reset state, and a load with no shifts still yields zeros
    expect_out('0, "R5 reset outputs");
    pulse_load();
    expect_out('0, "R5 load after reset");

    // R2: field split and bit order with known words
    shift_word(16'b10_00000000000001);
    pulse_load();
    expect_out(16'h8001, "R2 first bit to switch_o[1], last bit to N LSB");
    shift_word(16'b01_10000000000000);
    pulse_load();
    expect_out(16'h6000, "R2 second bit to switch_o[0], third bit to N MSB");

    // R4 and R1: random words; hold while shifting, then update on load
    for (int k = 0; k < 8; k++) begin
      w = W'($urandom);
      shift_word(w);
      expect_out(held, "R4 hold while shifting with enable low");
      pulse_load();
      expect_out(w, "R1 R2 random word loaded");
    end

    // R6: partial word keeps older bits
    shift_word(16'h1234);
    pulse_load();
    shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b0);
    pulse_load();
    expect_out(16'h234A, "R6 partial word after four shifts");

    // R7: over-long stream keeps the last 16 bits
    shift_bit(1'b1); shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
    shift_word(16'hA5C3);
    pulse_load();
    expect_out(16'hA5C3, "R7 only last 16 bits kept");

    // R3: enable held high, outputs track each bit
    load_en = 1'b1;
    repeat (SET) @(negedge clk);
    for (int i = 0; i < W; i++) begin
      shift_bit(1'($urandom));
      expect_out(mdl_sr, "R3 transparent tracking");
    end
    load_en = 1'b0;
    repeat (SET) @(negedge clk);
    held = mdl_sr;

    // R4: closed again, a new word must not show
    shift_word(~mdl_sr);
    expect_out(held, "R4 hold after transparent phase");

    done = 1;
    summary();
    $finish;
  end
endmodule